// File: doc/BRIEF.md
# Packet-Filter Instruction Legality Checker

This block examines a stream of 64-bit instruction slots for an in-kernel packet-filter virtual machine. For each slot it decides whether the slot is well formed. A strobed slot enters on one clock edge. On the next edge the block returns a legal flag, a 3-bit reason code, and a flag that marks the slot as the second half of a wide-immediate load.

The block checks structure only, field by field and by opcode class:

- The opcode must be a defined encoding.
- Both register numbers must be in range.
- Every field the opcode leaves unused must be zero.
- The immediate is checked where the opcode limits its value.

The block holds one bit of state. The 64-bit immediate load takes two slots, and the block must know when the next slot is a continuation that must not be decoded as an opcode. A loader feeds a program slot by slot and marks the final slot. If a wide load arrives as the final slot, it is reported as truncated.

Top module: `pfchk_top`

## Requirements
- R1: A slot strobed with `in_valid` at a clock edge yields `out_valid` high, with its result, after that edge for exactly one cycle. `out_valid` is low when no slot was strobed and after reset, and reset clears any pending continuation.
- R2: Slot layout is opcode [7:0], destination register [11:8], source register [15:12], signed offset [31:16] and immediate [63:32]. A register field of 11 or more in either field gives reason 2 (bad register).
- R3: The class is opcode[2:0]: 0 wide load, 1 load-from-memory, 2 store-immediate, 3 store-register, 4 32-bit arithmetic, 5 jump, 6 32-bit jump, 7 64-bit arithmetic. An undefined opcode gives reason 1 (bad opcode).
- R4: In the arithmetic classes, the operation is opcode[7:4] and opcode[3] selects register (1) or immediate (0) source. Operations 0x0 to 0xc are defined, except that negate (0x8) has only the immediate form. Byte swap 0xd4 and 0xdc exists only in class 4, and operations 0xe and 0xf are undefined.
- R5: In class 5, jump-always 0x05, call 0x85 and exit 0x95 are the only non-compare encodings. The compare operations 0x1 to 0x7 and 0xa to 0xd are defined in both forms. Class 6 defines only the compare operations.
- R6: Memory classes accept mode bits [7:5]=011 with any size bits [4:3]. Class 3 also accepts atomic opcodes 0xc3 and 0xdb.
- R7: A nonzero unused field gives reason 3 (reserved nonzero). The unused fields are:
  - source in every immediate form;
  - immediate in every register form;
  - offset in arithmetic and wide-load slots;
  - everything but the offset for jump-always;
  - everything but the immediate for call;
  - all fields for exit;
  - immediate for memory loads and register stores;
  - source for store-immediate.
- R8: Byte-swap opcodes need an immediate of 16, 32 or 64; any other value gives reason 4 (bad immediate).
- R9: Atomic opcodes need an immediate in {0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xa0, 0xa1, 0xe1, 0xf1}; any other value gives reason 4.
- R10: The next strobed slot after opcode 0x18, with any number of idle cycles between, is a continuation and sets `out_cont`. It is legal when its opcode, registers and offset are all zero, whatever its immediate holds; otherwise it gives reason 3. It never arms a further continuation.
- R11: Opcode 0x18 strobed with `in_last` high gives reason 5 (truncated) when no higher reason applies, and arms no continuation.
- R12: Reasons rank bad opcode, bad register, reserved nonzero, bad immediate, truncated. Reason 0 means legal, and `out_legal` is high exactly when the reason is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Slot strobe |
| in_slot | input | 64 | Instruction slot |
| in_last | input | 1 | Marks the final slot of a program |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_legal | output | 1 | Slot is well formed |
| out_reason | output | 3 | 0 ok, 1 bad opcode, 2 bad register, 3 reserved nonzero, 4 bad immediate, 5 truncated |
| out_cont | output | 1 | Slot was taken as a wide-load continuation |

## Verification
The only hidden state is the pending-continuation bit. A wrong value shows at the ports on the very next strobed slot, one cycle after its strobe:

- If the bit is lost, a continuation is decoded as an opcode. The result is a spurious bad-opcode verdict and a low `out_cont`.
- If the bit sticks, an ordinary slot is reported as a continuation.

The bench therefore follows each wide load with both a clean continuation and a non-zero one, with idle gaps and back-to-back timing, and then sends an ordinary slot. Decode errors show on the same result cycle as a wrong reason code. The directed vectors sit on each class boundary and on each rank of the reason priority.

// File: rtl/pfchk_pkg.sv
package pfchk_pkg;

  localparam int SLOT_W = 64;
  localparam int OPC_W  = 8;
  localparam int REG_W  = 4;
  localparam int OFF_W  = 16;
  localparam int IMM_W  = 32;
  localparam int RSN_W  = 3;

  typedef enum logic [RSN_W-1:0] {
    RSN_OK      = 3'd0,
    RSN_BAD_OPC = 3'd1,
    RSN_BAD_REG = 3'd2,
    RSN_RSVD    = 3'd3,
    RSN_BAD_IMM = 3'd4,
    RSN_TRUNC   = 3'd5
  } reason_e;

  typedef enum logic [2:0] {
    CL_LD    = 3'd0,
    CL_LDX   = 3'd1,
    CL_ST    = 3'd2,
    CL_STX   = 3'd3,
    CL_ALU   = 3'd4,
    CL_JMP   = 3'd5,
    CL_JMP32 = 3'd6,
    CL_ALU64 = 3'd7
  } class_e;

  typedef enum logic [1:0] {
    IMMR_ANY    = 2'd0,
    IMMR_SWAP   = 2'd1,
    IMMR_ATOMIC = 2'd2
  } immrule_e;

  typedef struct packed {
    logic [IMM_W-1:0] imm;
    logic [OFF_W-1:0] off;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
    logic [OPC_W-1:0] opc;
  } slot_t;

  typedef struct packed {
    logic     known;
    logic     dst_used;
    logic     src_used;
    logic     off_used;
    logic     imm_used;
    immrule_e rule;
    logic     wide;
  } shape_t;

  localparam logic [OPC_W-1:0] OPC_WIDE = 8'h18;

  // Field usage and legality of one opcode, chosen by class first.
  function automatic shape_t op_shape(input logic [OPC_W-1:0] opc);
    shape_t     s;
    logic [3:0] op;
    logic       regsrc;
    logic       j32;
    s      = '0;
    op     = opc[7:4];
    regsrc = opc[3];
    j32    = (opc[2:0] == CL_JMP32);
    case (opc[2:0])
      CL_ALU, CL_ALU64: begin
        if (op <= 4'hc) begin
          s.dst_used = 1'b1;
          if (op == 4'h8) begin
            s.known = !regsrc;
          end else begin
            s.known    = 1'b1;
            s.src_used = regsrc;
            s.imm_used = !regsrc;
          end
        end else if (op == 4'hd && opc[2:0] == CL_ALU) begin
          s.known    = 1'b1;
          s.dst_used = 1'b1;
          s.imm_used = 1'b1;
          s.rule     = IMMR_SWAP;
        end
      end
      CL_JMP, CL_JMP32: begin
        case (op)
          4'h0: begin
            s.known    = !regsrc && !j32;
            s.off_used = 1'b1;
          end
          4'h8: begin
            s.known    = !regsrc && !j32;
            s.imm_used = 1'b1;
          end
          4'h9: s.known = !regsrc && !j32;
          4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7,
          4'ha, 4'hb, 4'hc, 4'hd: begin
            s.known    = 1'b1;
            s.dst_used = 1'b1;
            s.off_used = 1'b1;
            s.src_used = regsrc;
            s.imm_used = !regsrc;
          end
          default: s.known = 1'b0;
        endcase
      end
      CL_LD: begin
        if (opc == OPC_WIDE) begin
          s.known    = 1'b1;
          s.dst_used = 1'b1;
          s.imm_used = 1'b1;
          s.wide     = 1'b1;
        end
      end
      CL_LDX: begin
        if (opc[7:5] == 3'b011) begin
          s.known    = 1'b1;
          s.dst_used = 1'b1;
          s.src_used = 1'b1;
          s.off_used = 1'b1;
        end
      end
      CL_ST: begin
        if (opc[7:5] == 3'b011) begin
          s.known    = 1'b1;
          s.dst_used = 1'b1;
          s.off_used = 1'b1;
          s.imm_used = 1'b1;
        end
      end
      default: begin
        if (opc[7:5] == 3'b011) begin
          s.known    = 1'b1;
          s.dst_used = 1'b1;
          s.src_used = 1'b1;
          s.off_used = 1'b1;
        end else if (opc == 8'hc3 || opc == 8'hdb) begin
          s.known    = 1'b1;
          s.dst_used = 1'b1;
          s.src_used = 1'b1;
          s.off_used = 1'b1;
          s.imm_used = 1'b1;
          s.rule     = IMMR_ATOMIC;
        end
      end
    endcase
    return s;
  endfunction

  function automatic logic imm_fits(input immrule_e rule, input logic [IMM_W-1:0] imm);
    case (rule)
      IMMR_SWAP:   return imm == 32'd16 || imm == 32'd32 || imm == 32'd64;
      IMMR_ATOMIC: return imm inside {32'h00, 32'h01, 32'h40, 32'h41, 32'h50,
                                      32'h51, 32'ha0, 32'ha1, 32'he1, 32'hf1};
      default:     return 1'b1;
    endcase
  endfunction

  function automatic logic unused_nonzero(input shape_t s, input slot_t t);
    return (!s.dst_used && t.dst != '0) || (!s.src_used && t.src != '0) ||
           (!s.off_used && t.off != '0) || (!s.imm_used && t.imm != '0);
  endfunction

  function automatic logic cont_clear(input slot_t t);
    return t.opc == '0 && t.dst == '0 && t.src == '0 && t.off == '0;
  endfunction

endpackage

// File: rtl/pfchk_decode.sv
module pfchk_decode
  import pfchk_pkg::*;
#(
  parameter int NUM_REGS = 11
) (
  input  slot_t  slot_i,
  output shape_t shape_o,
  output logic   bad_reg_o,
  output logic   rsvd_nz_o,
  output logic   imm_bad_o
);

  always_comb begin
    shape_o   = op_shape(slot_i.opc);
    bad_reg_o = (int'(slot_i.dst) >= NUM_REGS) || (int'(slot_i.src) >= NUM_REGS);
    rsvd_nz_o = unused_nonzero(shape_o, slot_i);
    imm_bad_o = !imm_fits(shape_o.rule, slot_i.imm);
  end

endmodule

// File: rtl/pfchk_slot_track.sv
module pfchk_slot_track (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic wide_i,
  input  logic last_i,
  output logic pend_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
    end else if (strobe_i) begin
      pend_o <= pend_o ? 1'b0 : (wide_i && !last_i);
    end
  end

endmodule

// File: rtl/pfchk_top.sv
module pfchk_top
  import pfchk_pkg::*;
#(
  parameter int NUM_REGS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic              in_last,
  output logic              out_valid,
  output logic              out_legal,
  output logic [RSN_W-1:0]  out_reason,
  output logic              out_cont
);

  slot_t   slot;
  shape_t  shape;
  logic    bad_reg, rsvd_nz, imm_bad;
  logic    pend_q;
  logic    ev_cont, ev_trunc;
  reason_e reason_d;

  assign slot = slot_t'(in_slot);

  pfchk_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .slot_i    (slot),
    .shape_o   (shape),
    .bad_reg_o (bad_reg),
    .rsvd_nz_o (rsvd_nz),
    .imm_bad_o (imm_bad)
  );

  pfchk_slot_track u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (in_valid),
    .wide_i   (shape.wide),
    .last_i   (in_last),
    .pend_o   (pend_q)
  );

  assign ev_cont  = in_valid && pend_q;
  assign ev_trunc = in_valid && !pend_q && shape.wide && in_last;

  always_comb begin
    if (pend_q)             reason_d = cont_clear(slot) ? RSN_OK : RSN_RSVD;
    else if (!shape.known)  reason_d = RSN_BAD_OPC;
    else if (bad_reg)       reason_d = RSN_BAD_REG;
    else if (rsvd_nz)       reason_d = RSN_RSVD;
    else if (imm_bad)       reason_d = RSN_BAD_IMM;
    else if (shape.wide && in_last) reason_d = RSN_TRUNC;
    else                    reason_d = RSN_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_legal  <= 1'b0;
      out_reason <= RSN_OK;
      out_cont   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_legal  <= (reason_d == RSN_OK);
        out_reason <= reason_d;
        out_cont   <= ev_cont;
      end
    end
  end

endmodule

// File: rtl/pfchk_sva.sv
module pfchk_sva #(
  parameter int NUM_REGS = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_last,
  input logic [63:0] in_slot,
  input logic        pend_q,
  input logic        ev_trunc,
  input logic        out_valid,
  input logic        out_legal,
  input logic [2:0]  out_reason,
  input logic        out_cont
);

  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r12_legal_matches: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_legal == (out_reason == 3'd0)));

  a_r12_reason_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_reason <= 3'd5));

  a_r10_cont_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pend_q) |=> (out_cont && !pend_q));

  a_r11_trunc_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trunc |=> (!pend_q && !out_cont));

  a_r2_reg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pend_q && (int'(in_slot[11:8]) >= NUM_REGS || int'(in_slot[15:12]) >= NUM_REGS))
    |=> (out_reason == 3'd1 || out_reason == 3'd2));

  a_r11_last_only_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last) |=> (out_reason != 3'd5));

endmodule

bind pfchk_top pfchk_sva #(.NUM_REGS(NUM_REGS)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_last    (in_last),
  .in_slot    (in_slot),
  .pend_q     (pend_q),
  .ev_trunc   (ev_trunc),
  .out_valid  (out_valid),
  .out_legal  (out_legal),
  .out_reason (out_reason),
  .out_cont   (out_cont)
);

// File: tb/tb_pfchk_top.sv
module tb_pfchk_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_slot = '0;
  logic        in_last = 1'b0;
  logic        out_valid, out_legal, out_cont;
  logic [2:0]  out_reason;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pfchk_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot(in_slot),
    .in_last(in_last), .out_valid(out_valid), .out_legal(out_legal),
    .out_reason(out_reason), .out_cont(out_cont)
  );

  function automatic logic [63:0] mk(input logic [7:0] opc, input logic [3:0] d,
                                     input logic [3:0] s, input logic [15:0] off,
                                     input logic [31:0] imm);
    return {imm, off, s, d, opc};
  endfunction

  task automatic expect_out(input string tag, input logic [2:0] er, input logic ec);
    checks++;
    if (out_valid !== 1'b1 || out_reason !== er || out_legal !== (er == 3'd0) || out_cont !== ec) begin
      errors++;
      $display("FAIL %s: valid=%0b reason=%0d legal=%0b cont=%0b expected valid=1 reason=%0d cont=%0b",
               tag, out_valid, out_reason, out_legal, out_cont, er, ec);
    end
  endtask

  task automatic push(input string tag, input logic [63:0] w, input logic last,
                      input logic [2:0] er, input logic ec);
    @(negedge clk);
    in_valid = 1'b1; in_slot = w; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    expect_out(tag, er, ec);
  endtask

  task automatic push_pair(input string tag, input logic [63:0] a, input logic [63:0] b,
                           input logic [2:0] ea, input logic eca,
                           input logic [2:0] eb, input logic ecb);
    @(negedge clk);
    in_valid = 1'b1; in_slot = a; in_last = 1'b0;
    @(negedge clk);
    expect_out({tag, " first"}, ea, eca);
    in_slot = b;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out({tag, " second"}, eb, ecb);
  endtask

  task automatic t_reset();
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: out_valid=%0b expected 0", out_valid);
    end
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: out_valid=%0b expected 0", out_valid);
    end
  endtask

  task automatic t_alu();
    push("R4 add64 imm", mk(8'h07, 1, 0, 0, 5), 0, 0, 0);
    push("R4 mov64 reg", mk(8'hbf, 2, 3, 0, 0), 0, 0, 0);
    push("R4 neg32", mk(8'h84, 1, 0, 0, 0), 0, 0, 0);
    push("R4 neg reg form", mk(8'h8c, 1, 2, 0, 0), 0, 1, 0);
    push("R4 swap in alu64", mk(8'hd7, 1, 0, 0, 16), 0, 1, 0);
    push("R4 op e", mk(8'he7, 1, 0, 0, 0), 0, 1, 0);
    push("R3 class7 op f", mk(8'hf7, 1, 0, 0, 0), 0, 1, 0);
    push("R7 alu offset", mk(8'h34, 1, 0, 16'h0004, 3), 0, 3, 0);
    push("R7 alu K src", mk(8'h04, 1, 2, 0, 3), 0, 3, 0);
    push("R7 alu X imm", mk(8'h0c, 1, 2, 0, 3), 0, 3, 0);
  endtask

  task automatic t_regs();
    push("R2 dst 11", mk(8'h0f, 11, 1, 0, 0), 0, 2, 0);
    push("R2 src 15", mk(8'h0f, 1, 15, 0, 0), 0, 2, 0);
    push("R2 r10 ok", mk(8'hbf, 10, 10, 0, 0), 0, 0, 0);
    push("R12 opc over reg", mk(8'hff, 12, 0, 0, 0), 0, 1, 0);
    push("R12 reg over rsvd", mk(8'h95, 11, 0, 0, 1), 0, 2, 0);
  endtask

  task automatic t_jumps();
    push("R5 ja", mk(8'h05, 0, 0, 16'h0003, 0), 0, 0, 0);
    push("R5 call", mk(8'h85, 0, 0, 0, 7), 0, 0, 0);
    push("R5 exit", mk(8'h95, 0, 0, 0, 0), 0, 0, 0);
    push("R7 exit imm", mk(8'h95, 0, 0, 0, 1), 0, 3, 0);
    push("R7 ja dst", mk(8'h05, 1, 0, 16'h0003, 0), 0, 3, 0);
    push("R7 call off", mk(8'h85, 0, 0, 16'h0001, 7), 0, 3, 0);
    push("R5 jmp32 ja", mk(8'h06, 0, 0, 16'h0003, 0), 0, 1, 0);
    push("R5 jmp32 call", mk(8'h86, 0, 0, 0, 7), 0, 1, 0);
    push("R5 jmp32 exit", mk(8'h96, 0, 0, 0, 0), 0, 1, 0);
    push("R5 ja reg form", mk(8'h0d, 0, 0, 16'h0003, 0), 0, 1, 0);
    push("R5 jmp op e", mk(8'he5, 1, 0, 16'h0003, 0), 0, 1, 0);
    push("R5 jeq32 reg", mk(8'h1e, 1, 2, 16'hfffe, 0), 0, 0, 0);
    push("R5 jsle imm", mk(8'hd5, 3, 0, 16'h0002, 32'hffffffff), 0, 0, 0);
    push("R7 jeq K src", mk(8'h15, 1, 1, 16'h0002, 4), 0, 3, 0);
  endtask

  task automatic t_mem();
    push("R6 ldx word", mk(8'h61, 1, 2, 16'h0008, 0), 0, 0, 0);
    push("R6 stx dword", mk(8'h7b, 10, 1, 16'hfff8, 0), 0, 0, 0);
    push("R7 st src", mk(8'h62, 1, 1, 0, 9), 0, 3, 0);
    push("R7 stx imm", mk(8'h63, 1, 2, 0, 1), 0, 3, 0);
    push("R6 ldx bad mode", mk(8'h41, 1, 2, 0, 0), 0, 1, 0);
  endtask

  task automatic t_swap();
    push("R8 le16", mk(8'hd4, 1, 0, 0, 16), 0, 0, 0);
    push("R8 be64", mk(8'hdc, 1, 0, 0, 64), 0, 0, 0);
    push("R8 be imm 8", mk(8'hdc, 1, 0, 0, 8), 0, 4, 0);
    push("R12 rsvd over imm", mk(8'hd4, 1, 1, 0, 7), 0, 3, 0);
  endtask

  task automatic t_atomic();
    push("R9 cmpxchg64", mk(8'hdb, 1, 2, 0, 32'hf1), 0, 0, 0);
    push("R9 fetch-or32", mk(8'hc3, 1, 2, 0, 32'h41), 0, 0, 0);
    push("R9 imm 0x02", mk(8'hdb, 1, 2, 0, 32'h02), 0, 4, 0);
    push("R9 imm 0xe0", mk(8'hc3, 1, 2, 0, 32'he0), 0, 4, 0);
  endtask

  task automatic t_wide();
    push("R10 head", mk(8'h18, 1, 0, 0, 32'h12345678), 0, 0, 0);
    push("R10 tail clean", mk(8'h00, 0, 0, 0, 32'hdeadbeef), 0, 0, 1);
    push("R10 after pair", mk(8'h07, 1, 0, 0, 1), 0, 0, 0);
    push_pair("R10 b2b", mk(8'h18, 2, 0, 0, 1), mk(8'h07, 0, 0, 0, 0), 0, 0, 3, 1);
    push_pair("R10 b2b tail", mk(8'h18, 2, 0, 0, 1), mk(8'h00, 0, 0, 0, 32'hffffffff), 0, 0, 0, 1);
    push("R10 head again", mk(8'h18, 3, 0, 0, 0), 0, 0, 0);
    push("R10 tail looks wide", mk(8'h18, 0, 0, 0, 5), 0, 3, 1);
    push("R10 no rearm", mk(8'hbf, 1, 2, 0, 0), 0, 0, 0);
    push("R10 gap head", mk(8'h18, 4, 0, 0, 0), 0, 0, 0);
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 gap idle: out_valid=%0b expected 0", out_valid);
    end
    push("R10 gap tail last", mk(8'h00, 0, 0, 0, 32'h1), 1, 0, 1);
    push("R10 tail off", mk(8'h18, 4, 0, 0, 0), 0, 0, 0);
    push("R10 tail off nz", mk(8'h00, 0, 0, 16'h0001, 0), 0, 3, 1);
  endtask

  task automatic t_trunc();
    push("R11 trunc", mk(8'h18, 1, 0, 0, 9), 1, 5, 0);
    push("R11 not armed", mk(8'h07, 1, 0, 0, 2), 0, 0, 0);
    push("R12 reg over trunc", mk(8'h18, 11, 0, 0, 9), 1, 2, 0);
    push("R11 last on plain", mk(8'h95, 0, 0, 0, 0), 1, 0, 0);
  endtask

  task automatic t_reset_clears();
    push("R1 head before reset", mk(8'h18, 1, 0, 0, 0), 0, 0, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    push("R1 reset cleared pending", mk(8'h07, 1, 0, 0, 0), 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_alu();
    t_regs();
    t_jumps();
    t_mem();
    t_swap();
    t_atomic();
    t_wide();
    t_trunc();
    t_reset_clears();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule